// File: doc/BRIEF.md
# Per-Channel Differential Phase Tracker for Frequency Hopping

This block builds the carrier phase of a frequency-hopping π/4-DQPSK transmitter one hop at a time. Each hop is announced by a one-cycle strobe that carries a 6-bit hop code and a 2-bit data symbol. The block keeps a separate absolute phase for every hop code. On each hop it advances the phase of the addressed code by the increment that the symbol selects. The carrier therefore picks up the phase it last had on that same frequency, so the receiver can demodulate differentially per channel.

Each hop code also selects a channel index from a writable 64-entry table. The frequency word for the hop is that index times a programmable step register, which sets the channel spacing. The new frequency word and the new phase word are presented together, in one registered update, with a one-cycle valid strobe. A downstream oscillator can load both at once and never runs the new frequency with a stale phase. A synchronous clear returns every per-channel phase to zero, so that both ends of a link can start from a common reference.

Top module: `hop_phase_tracker`

## Requirements
- R1: After reset, `upd_valid`, `upd_freq` and `upd_phase` are 0, every per-code phase is 0, every table index is 0 and the step register holds 0x0001_0000.
- R2: Symbol codes map to 12-bit phase increments as 2'b00 → 0x200, 2'b01 → 0x600, 2'b11 → 0xA00 and 2'b10 → 0xE00, where 0x200 is π/4.
- R3: On an accepted hop, the new phase is the stored phase of that hop code plus the symbol increment, modulo 4096. The new phase is written back to the same code's entry and shown on `upd_phase`.
- R4: A hop changes only the phase entry of its own hop code. The entries of all other codes are left as they were.
- R5: Writing `tbl_we` stores the 9-bit `tbl_idx` at the 6-bit `tbl_addr`. A hop's `upd_freq` is that code's index times the step register, truncated to 32 bits.
- R6: Writing `step_we` loads the 32-bit `step_val` into the step register that later hops use.
- R7: A hop strobe sampled at clock edge k gives `upd_valid` high for exactly the cycle after edge k+1. Strobes on consecutive cycles, including strobes on the same code, each give their own correctly chained update.
- R8: `upd_freq` and `upd_phase` change only in a cycle where `upd_valid` is high. At all other times they hold their last values, even when the table or the step register is written.
- R9: `clr` sets all 64 phase entries to zero and leaves the table and the step register unchanged. A hop strobe in the same cycle as `clr` is dropped: it produces no update and no write.
- R10: The table index and the step value used by a hop are the ones held in the strobe cycle. A write in that same cycle takes effect from the next hop on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all per-code phases |
| hop_stb | input | 1 | One-cycle hop strobe |
| hop_code | input | 6 | Hop code of the current hop |
| hop_sym | input | 2 | Data symbol of the current hop |
| tbl_we | input | 1 | Channel table write enable |
| tbl_addr | input | 6 | Channel table entry to write |
| tbl_idx | input | 9 | Channel index to store |
| step_we | input | 1 | Step register write enable |
| step_val | input | 32 | New step value |
| upd_valid | output | 1 | One-cycle strobe marking a new frequency/phase pair |
| upd_freq | output | 32 | Frequency word of the latest hop |
| upd_phase | output | 12 | Absolute phase word of the latest hop |

## Verification
The assertions assume that reset is held for at least two clock edges and that `hop_stb`, `clr`, `hop_code` and `hop_sym` carry known values whenever reset is low. The checks on held outputs and on grid-aligned phase depend on those conditions. The stimulus meets them: reset is held for several cycles, every input starts at a defined value, and all inputs change only on falling edges. Values set in one test are set on purpose and carried into the next, so the bench reference model tracks every phase entry across tests.

// File: rtl/hop_phase_pkg.sv
package hop_phase_pkg;

    localparam int CODE_W = 6;
    localparam int NCODE  = 1 << CODE_W;
    localparam int PH_W   = 12;
    localparam int CH_W   = 9;
    localparam int FW_W   = 32;

    // One eighth of a full turn: the pi/4 step of the phase word.
    localparam logic [PH_W-1:0] EIGHTH = PH_W'(1) << (PH_W - 3);

    typedef enum logic [1:0] {
        SYM_P1 = 2'b00,   // +pi/4
        SYM_P3 = 2'b01,   // +3pi/4
        SYM_M1 = 2'b10,   // -pi/4
        SYM_M3 = 2'b11    // -3pi/4
    } sym_e;

    typedef struct packed {
        logic [CH_W-1:0] idx;
        logic [FW_W-1:0] step;
        logic [PH_W-1:0] phase;
    } hop_stage_t;

    function automatic logic [PH_W-1:0] sym_to_dphase(input sym_e s);
        case (s)
            SYM_P1:  return EIGHTH;
            SYM_P3:  return PH_W'(3) * EIGHTH;
            SYM_M3:  return PH_W'(5) * EIGHTH;
            default: return PH_W'(7) * EIGHTH;
        endcase
    endfunction

endpackage

// File: rtl/hop_phase_store.sv
module hop_phase_store
    import hop_phase_pkg::*;
#(
    parameter int ENTRIES = NCODE,
    parameter int W       = PH_W,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R3: an accepted write lands in the addressed entry
    a_r3_writeback: assert property (@(posedge clk) disable iff (rst)
        (we && !clr) |=> mem[$past(waddr)] == $past(wdata));

    // R9: clear empties both ends of the store
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mem[0] == '0) && (mem[ENTRIES-1] == '0));

endmodule

// File: rtl/hop_chan_table.sv
module hop_chan_table
    import hop_phase_pkg::*;
#(
    parameter int             ENTRIES   = NCODE,
    parameter int             IDX_W     = CH_W,
    parameter int             STEP_W    = FW_W,
    parameter logic [STEP_W-1:0] STEP_INIT = 32'h0001_0000,
    localparam int            AW        = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              step_we,
    input  logic [STEP_W-1:0] step_val,
    input  logic [AW-1:0]     raddr,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [STEP_W-1:0] step_q
);

    logic [IDX_W-1:0] tab [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
        end else if (tbl_we) begin
            tab[tbl_addr] <= tbl_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          step_q <= STEP_INIT;
        else if (step_we) step_q <= step_val;
    end

    assign rd_idx = tab[raddr];

    // R5: a table write is visible at its address afterwards
    a_r5_table_write: assert property (@(posedge clk) disable iff (rst)
        tbl_we |=> tab[$past(tbl_addr)] == $past(tbl_idx));

    // R6: a step write is visible afterwards
    a_r6_step_load: assert property (@(posedge clk) disable iff (rst)
        step_we |=> step_q == $past(step_val));

endmodule

// File: rtl/hop_phase_tracker.sv
module hop_phase_tracker
    import hop_phase_pkg::*;
#(
    parameter logic [FW_W-1:0] STEP_INIT = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              hop_stb,
    input  logic [CODE_W-1:0] hop_code,
    input  logic [1:0]        hop_sym,
    input  logic              tbl_we,
    input  logic [CODE_W-1:0] tbl_addr,
    input  logic [CH_W-1:0]   tbl_idx,
    input  logic              step_we,
    input  logic [FW_W-1:0]   step_val,
    output logic              upd_valid,
    output logic [FW_W-1:0]   upd_freq,
    output logic [PH_W-1:0]   upd_phase
);

    logic              accept;
    logic [PH_W-1:0]   old_phase;
    logic [PH_W-1:0]   new_phase;
    logic [CH_W-1:0]   cur_idx;
    logic [FW_W-1:0]   cur_step;
    hop_stage_t        s1;
    logic              s1_vld;
    logic [FW_W-1:0]   freq_next;

    // Clear wins over a hop in the same cycle.
    assign accept    = hop_stb && !clr;
    assign new_phase = old_phase + sym_to_dphase(sym_e'(hop_sym));

    hop_phase_store #(.ENTRIES(NCODE), .W(PH_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .we    (accept),
        .waddr (hop_code),
        .wdata (new_phase),
        .raddr (hop_code),
        .rdata (old_phase)
    );

    hop_chan_table #(
        .ENTRIES(NCODE), .IDX_W(CH_W), .STEP_W(FW_W), .STEP_INIT(STEP_INIT)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_idx  (tbl_idx),
        .step_we  (step_we),
        .step_val (step_val),
        .raddr    (hop_code),
        .rd_idx   (cur_idx),
        .step_q   (cur_step)
    );

    // Stage 1: capture the operands of the hop in its strobe cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1     <= '0;
        end else begin
            s1_vld <= accept;
            if (accept) s1 <= '{idx: cur_idx, step: cur_step, phase: new_phase};
        end
    end

    assign freq_next = FW_W'(s1.idx) * s1.step;

    // Stage 2: release frequency and phase together.
    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid <= 1'b0;
            upd_freq  <= '0;
            upd_phase <= '0;
        end else begin
            upd_valid <= s1_vld;
            if (s1_vld) begin
                upd_freq  <= freq_next;
                upd_phase <= s1.phase;
            end
        end
    end

    // R7: an accepted hop yields an update two edges later
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 upd_valid);

    // R9: a hop that meets a clear yields no update
    a_r9_drop_on_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> ##1 !upd_valid);

    // R8: the output pair moves only with the valid strobe
    a_r8_hold_pair: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !$past(rst)) |-> ($stable(upd_freq) && $stable(upd_phase)));

    // R3: phases stay on the pi/4 grid
    a_r3_on_grid: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> upd_phase[PH_W-4:0] == '0);

endmodule

// File: tb/tb_hop_phase_tracker.sv
module tb_hop_phase_tracker;

    localparam logic [31:0] STEP_RST = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        hop_stb = 1'b0;
    logic [5:0]  hop_code = '0;
    logic [1:0]  hop_sym = '0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [8:0]  tbl_idx = '0;
    logic        step_we = 1'b0;
    logic [31:0] step_val = '0;
    logic        upd_valid;
    logic [31:0] upd_freq;
    logic [11:0] upd_phase;

    int checks = 0;
    int errors = 0;

    logic [11:0] mph  [64];
    logic [8:0]  mtab [64];
    logic [31:0] mstep;

    always #5 clk = ~clk;

    hop_phase_tracker dut (
        .clk(clk), .rst(rst), .clr(clr), .hop_stb(hop_stb), .hop_code(hop_code),
        .hop_sym(hop_sym), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_idx(tbl_idx),
        .step_we(step_we), .step_val(step_val), .upd_valid(upd_valid),
        .upd_freq(upd_freq), .upd_phase(upd_phase)
    );

    function automatic logic [11:0] ref_dph(input logic [1:0] s);
        case (s)
            2'b00:   return 12'h200;
            2'b01:   return 12'h600;
            2'b11:   return 12'hA00;
            default: return 12'hE00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One hop with optional same-cycle writes; checks the update it produces.
    task automatic hop(input logic [5:0] code, input logic [1:0] sym, input string tag,
                       input logic tw = 1'b0, input logic [8:0] tidx = '0,
                       input logic sw = 1'b0, input logic [31:0] sval = '0);
        logic [11:0] eph;
        logic [31:0] efq;
        eph = mph[code] + ref_dph(sym);
        efq = 32'(mtab[code]) * mstep;
        @(negedge clk);
        hop_stb = 1'b1; hop_code = code; hop_sym = sym;
        tbl_we = tw; tbl_addr = code; tbl_idx = tidx; step_we = sw; step_val = sval;
        @(negedge clk);
        hop_stb = 1'b0; tbl_we = 1'b0; step_we = 1'b0;
        chk("R7", "valid one edge after strobe", 32'(upd_valid), 32'd0);
        @(negedge clk);
        chk("R7", "valid two edges after strobe", 32'(upd_valid), 32'd1);
        chk(tag, "phase", 32'(upd_phase), 32'(eph));
        chk(tag, "freq", upd_freq, efq);
        mph[code] = eph;
        if (tw) mtab[code] = tidx;
        if (sw) mstep = sval;
    endtask

    task automatic wr_tbl(input logic [5:0] a, input logic [8:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_idx = v;
        @(negedge clk);
        tbl_we = 1'b0;
        mtab[a] = v;
    endtask

    task automatic wr_step(input logic [31:0] v);
        @(negedge clk);
        step_we = 1'b1; step_val = v;
        @(negedge clk);
        step_we = 1'b0;
        mstep = v;
    endtask

    task automatic t_reset_state;
        chk("R1", "valid after reset", 32'(upd_valid), 32'd0);
        chk("R1", "freq after reset", upd_freq, 32'd0);
        chk("R1", "phase after reset", 32'(upd_phase), 32'd0);
        hop(6'd9, 2'b00, "R1");          // table index 0 -> freq 0, phase from 0
        wr_tbl(6'd5, 9'd3);
        hop(6'd5, 2'b00, "R1");          // index 3 times reset step
    endtask

    task automatic t_symbols;            // R2, R3: every symbol, accumulated
        wr_tbl(6'd10, 9'd100);
        hop(6'd10, 2'b00, "R2");
        hop(6'd10, 2'b01, "R2");
        hop(6'd10, 2'b11, "R2");
        hop(6'd10, 2'b10, "R2");
        hop(6'd10, 2'b01, "R3");
    endtask

    task automatic t_wrap;               // R3: eight pi/4 steps return to start
        for (int i = 0; i < 8; i++) hop(6'd20, 2'b00, "R3");
        chk("R3", "wrapped phase", 32'(upd_phase), 32'h0);
        hop(6'd20, 2'b10, "R3");         // 0 - pi/4 wraps to 0xE00
    endtask

    task automatic t_independent;        // R4
        hop(6'd1, 2'b01, "R4");
        hop(6'd2, 2'b11, "R4");
        hop(6'd63, 2'b10, "R4");
        hop(6'd1, 2'b00, "R4");
        hop(6'd2, 2'b00, "R4");
    endtask

    task automatic t_step_freq;          // R5, R6
        wr_step(32'h1234_5678);
        wr_tbl(6'd7, 9'd511);
        hop(6'd7, 2'b00, "R5");
        wr_step(32'd3000);
        hop(6'd7, 2'b01, "R6");
        hop(6'd10, 2'b11, "R6");
    endtask

    task automatic t_back_to_back;       // R7: consecutive strobes, same code
        logic [11:0] e1, e2;
        e1 = mph[3] + ref_dph(2'b01);
        e2 = e1 + ref_dph(2'b11);
        @(negedge clk);
        hop_stb = 1'b1; hop_code = 6'd3; hop_sym = 2'b01;
        @(negedge clk);
        hop_sym = 2'b11;
        @(negedge clk);
        hop_stb = 1'b0;
        chk("R7", "first of pair valid", 32'(upd_valid), 32'd1);
        chk("R7", "first of pair phase", 32'(upd_phase), 32'(e1));
        @(negedge clk);
        chk("R7", "second of pair valid", 32'(upd_valid), 32'd1);
        chk("R7", "second of pair phase", 32'(upd_phase), 32'(e2));
        @(negedge clk);
        chk("R7", "valid single per hop", 32'(upd_valid), 32'd0);
        mph[3] = e2;
    endtask

    task automatic t_hold;               // R8
        logic [31:0] f0;
        logic [11:0] p0;
        hop(6'd7, 2'b11, "R8");
        f0 = upd_freq; p0 = upd_phase;
        wr_tbl(6'd7, 9'd12);
        wr_step(32'd77);
        repeat (3) @(negedge clk);
        chk("R8", "valid idle", 32'(upd_valid), 32'd0);
        chk("R8", "freq held", upd_freq, f0);
        chk("R8", "phase held", 32'(upd_phase), 32'(p0));
    endtask

    task automatic t_same_cycle_write;   // R10
        hop(6'd7, 2'b00, "R10", 1'b1, 9'd40, 1'b1, 32'd5);
        hop(6'd7, 2'b00, "R10");
    endtask

    task automatic t_clear;              // R9
        @(negedge clk);
        clr = 1'b1; hop_stb = 1'b1; hop_code = 6'd10; hop_sym = 2'b01;
        @(negedge clk);
        clr = 1'b0; hop_stb = 1'b0;
        chk("R9", "no update one edge after", 32'(upd_valid), 32'd0);
        @(negedge clk);
        chk("R9", "hop with clear dropped", 32'(upd_valid), 32'd0);
        for (int i = 0; i < 64; i++) mph[i] = '0;
        hop(6'd10, 2'b00, "R9");         // restarts from zero, table intact
        hop(6'd20, 2'b01, "R9");
        hop(6'd3, 2'b11, "R9");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin mph[i] = '0; mtab[i] = '0; end
        mstep = STEP_RST;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_symbols();
        t_wrap();
        t_independent();
        t_step_freq();
        t_back_to_back();
        t_hold();
        t_same_cycle_write();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule